// File: doc/BRIEF.md
# Nibble Accumulator and Carry Unit

This block is the arithmetic heart of a small calculator-style processor. It holds a 4-bit accumulator and a single carry/link flag. When a strobe arrives it performs one operation chosen by an opcode input. The operations are:

- add or subtract against a 4-bit operand taken from an external index register;
- increment and decrement;
- rotate left or right through the carry;
- clear, set and complement operations on the flags;
- a key-code compression step, which turns a one-hot key nibble into a small binary number.

Fetching, decoding and the index register file all live outside the block. The operand arrives on a plain input.

A bank-select operation copies the low three accumulator bits into a command-control register held in the block. That register drives an output so that neighbouring logic can select a memory bank. Every result is registered, and the new values appear one clock after the strobe edge. Strobes may arrive on consecutive cycles, and each operation then sees the result of the operation before it.

Top module: `nib_acc_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, the accumulator, the carry and the command register are all cleared to 0.
- R2: A cycle without `op_valid` changes nothing. The codes 0 (no-op) and 15 (reserved) also leave accumulator, carry and command register unchanged.
- R3: Code 1 (add) writes acc + operand + carry into the block. The low 4 bits go to the accumulator and bit 4 goes to the carry.
- R4: Code 2 (subtract) computes acc + (15 − operand) + carry. Here a carry of 1 means no borrow is pending. The low 4 bits go to the accumulator and bit 4 goes to the carry.
- R5: Code 3 (increment) adds 1, and the carry becomes 1 only when the accumulator wraps from 15 to 0. Code 4 (decrement) subtracts 1, and the carry becomes 1 when the old accumulator was nonzero and 0 when it wraps from 0 to 15.
- R6: Code 5 (rotate left) treats carry and accumulator as a 5-bit ring: the new accumulator is {acc[2:0], old carry} and the new carry is acc[3]. Code 6 (rotate right) gives a new accumulator of {old carry, acc[3:1]} and a new carry of acc[0].
- R7: Code 7 clears both accumulator and carry. Code 8 clears the carry, code 9 sets the carry and code 10 complements the carry, all three leaving the accumulator unchanged. Code 11 complements the accumulator and leaves the carry unchanged.
- R8: Code 12 (key compress) maps the accumulator values 0, 1, 2, 4 and 8 to 0, 1, 2, 3 and 4. Any value with more than one bit set becomes 15. The carry is unchanged.
- R9: Code 13 (bank select) loads acc[2:0] into the command register and leaves accumulator and carry unchanged. No other code touches the command register.
- R10: Code 14 (load operand) copies the operand into the accumulator and leaves the carry unchanged.
- R11: Results are visible on the outputs one clock after the strobe edge. A strobe on the very next cycle operates on that updated state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Strobe: execute `op_code` at this edge |
| op_code | input | 4 | Operation select (codes per R2 to R10) |
| idx_val | input | 4 | Operand from the external index register |
| acc_q | output | 4 | Accumulator |
| cy_q | output | 1 | Carry/link flag |
| cmd_sel | output | 3 | Command-control register (bank select) |

## Verification
Two functions can collide in a single cycle. One is an accumulator-writing operation at one edge. The other is a bank select or a dependent arithmetic step at the very next edge, which must read the freshly written accumulator rather than the stale one. The bench provokes this by issuing strobes on consecutive cycles: a load of the operand followed at once by a bank select, and a chain of add then rotate with no idle gap. It judges each step against its own reference model, which is carried forward from the previous expected state.

// File: rtl/nib_acc_pkg.sv
// Package: shared opcode encoding for the nibble accumulator unit.
// Assumes a 4-bit opcode field; code 15 is reserved and treated as no-op.
package nib_acc_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NOP  = 4'd0,
        OP_ADD  = 4'd1,
        OP_SUB  = 4'd2,
        OP_INC  = 4'd3,
        OP_DEC  = 4'd4,
        OP_RAL  = 4'd5,
        OP_RAR  = 4'd6,
        OP_CLB  = 4'd7,
        OP_CLC  = 4'd8,
        OP_STC  = 4'd9,
        OP_CMC  = 4'd10,
        OP_CMA  = 4'd11,
        OP_KEY  = 4'd12,
        OP_BSEL = 4'd13,
        OP_LDI  = 4'd14,
        OP_RSVD = 4'd15
    } nib_op_e;

    // Adder operand selection used by the arithmetic group.
    typedef enum logic [1:0] {
        OPND_IDX  = 2'd0,
        OPND_NIDX = 2'd1,
        OPND_ZERO = 2'd2,
        OPND_ONES = 2'd3
    } opnd_sel_e;

endpackage

// File: rtl/nib_adder.sv
// Module: nib_adder
// Purpose: W-bit ripple-free adder with carry in and carry out.
// Assumes: the operands are already selected/complemented by the caller.
module nib_adder #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         c_in,
    output logic [W-1:0] sum_out,
    output logic         c_out
);

    localparam int SW = W + 1;

    logic [SW-1:0] total;

    // Widen both operands by one bit so the carry falls out of the top.
    always_comb begin
        total   = {1'b0, a_in} + {1'b0, b_in} + {{W{1'b0}}, c_in};
        sum_out = total[W-1:0];
        c_out   = total[W];
    end

endmodule

// File: rtl/nib_keycode.sv
// Module: nib_keycode
// Purpose: compresses a one-hot key vector into a 1-based bit index.
//          Zero input yields 0; more than one set bit yields all ones.
// Assumes: W+1 fits in W bits as an index (true for W >= 2).
module nib_keycode #(
    parameter int W = 4
) (
    input  logic [W-1:0] key_in,
    output logic [W-1:0] code_out
);

    localparam int CNT_W = $clog2(W + 1);

    logic [W-1:0]     hit_code [W];
    logic [CNT_W-1:0] hit_cnt;
    logic [W-1:0]     merged;

    // One lane per input bit: each lane offers its 1-based position when set.
    for (genvar g = 0; g < W; g++) begin : g_lane
        assign hit_code[g] = key_in[g] ? W'(g + 1) : '0;
    end

    // Merge the lanes and count how many bits were set.
    always_comb begin
        merged  = '0;
        hit_cnt = '0;
        for (int i = 0; i < W; i++) begin
            merged  = merged | hit_code[i];
            hit_cnt = hit_cnt + CNT_W'(key_in[i]);
        end
    end

    // More than one set bit is flagged with the all-ones error code.
    always_comb begin
        if (hit_cnt > CNT_W'(1)) begin
            code_out = '1;
        end else begin
            code_out = merged;
        end
    end

endmodule

// File: rtl/nib_op_core.sv
// Module: nib_op_core
// Purpose: combinational next-state logic for accumulator and carry,
//          plus the load enable for the command-control register.
// Assumes: the caller qualifies the result with its own strobe.
module nib_op_core
    import nib_acc_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [OP_W-1:0] op_in,
    input  logic [W-1:0]    acc_in,
    input  logic            cy_in,
    input  logic [W-1:0]    idx_in,
    output logic [W-1:0]    acc_nx,
    output logic            cy_nx,
    output logic            cmd_ld
);

    nib_op_e       op;
    opnd_sel_e     opnd_sel;
    logic [W-1:0]  add_b;
    logic          add_ci;
    logic [W-1:0]  add_sum;
    logic          add_co;
    logic [W-1:0]  key_code;

    // Interpret the raw opcode bits as the enumerated operation.
    always_comb begin
        op = nib_op_e'(op_in);
    end

    // Choose the adder's second operand and carry in for the arithmetic group.
    always_comb begin
        unique case (op)
            OP_ADD:  begin opnd_sel = OPND_IDX;  add_ci = cy_in; end
            OP_SUB:  begin opnd_sel = OPND_NIDX; add_ci = cy_in; end
            OP_INC:  begin opnd_sel = OPND_ZERO; add_ci = 1'b1;  end
            OP_DEC:  begin opnd_sel = OPND_ONES; add_ci = 1'b0;  end
            default: begin opnd_sel = OPND_IDX;  add_ci = 1'b0;  end
        endcase
    end

    // Operand multiplexer feeding the shared adder.
    always_comb begin
        unique case (opnd_sel)
            OPND_IDX:  add_b = idx_in;
            OPND_NIDX: add_b = ~idx_in;
            OPND_ZERO: add_b = '0;
            default:   add_b = '1;
        endcase
    end

    nib_adder #(.W(W)) u_adder (
        .a_in    (acc_in),
        .b_in    (add_b),
        .c_in    (add_ci),
        .sum_out (add_sum),
        .c_out   (add_co)
    );

    nib_keycode #(.W(W)) u_key (
        .key_in   (acc_in),
        .code_out (key_code)
    );

    // Select the next accumulator and carry for the current operation.
    always_comb begin
        acc_nx = acc_in;
        cy_nx  = cy_in;
        cmd_ld = 1'b0;
        unique case (op)
            OP_ADD, OP_SUB, OP_INC, OP_DEC: begin
                acc_nx = add_sum;
                cy_nx  = add_co;
            end
            OP_RAL: begin
                acc_nx = {acc_in[W-2:0], cy_in};
                cy_nx  = acc_in[W-1];
            end
            OP_RAR: begin
                acc_nx = {cy_in, acc_in[W-1:1]};
                cy_nx  = acc_in[0];
            end
            OP_CLB: begin
                acc_nx = '0;
                cy_nx  = 1'b0;
            end
            OP_CLC:  cy_nx  = 1'b0;
            OP_STC:  cy_nx  = 1'b1;
            OP_CMC:  cy_nx  = ~cy_in;
            OP_CMA:  acc_nx = ~acc_in;
            OP_KEY:  acc_nx = key_code;
            OP_BSEL: cmd_ld = 1'b1;
            OP_LDI:  acc_nx = idx_in;
            default: begin
                acc_nx = acc_in;
                cy_nx  = cy_in;
            end
        endcase
    end

endmodule

// File: rtl/nib_acc_unit.sv
// Module: nib_acc_unit (top)
// Purpose: registers the accumulator, carry and command-control register
//          and applies one operation per op_valid strobe.
// Assumes: synchronous active-low reset; CW <= DW.
module nib_acc_unit
    import nib_acc_pkg::*;
#(
    parameter int DW = 4,
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [3:0]    op_code,
    input  logic [DW-1:0] idx_val,
    output logic [DW-1:0] acc_q,
    output logic          cy_q,
    output logic [CW-1:0] cmd_sel
);

    localparam int KEY_MAX = DW;

    logic [DW-1:0] acc_r;
    logic          cy_r;
    logic [CW-1:0] cmd_r;
    logic [DW-1:0] acc_nx;
    logic          cy_nx;
    logic          cmd_ld;

    nib_op_core #(.W(DW)) u_core (
        .op_in  (op_code),
        .acc_in (acc_r),
        .cy_in  (cy_r),
        .idx_in (idx_val),
        .acc_nx (acc_nx),
        .cy_nx  (cy_nx),
        .cmd_ld (cmd_ld)
    );

    // State registers: reset to zero, update only on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_r <= '0;
            cy_r  <= 1'b0;
            cmd_r <= '0;
        end else if (op_valid) begin
            acc_r <= acc_nx;
            cy_r  <= cy_nx;
            if (cmd_ld) begin
                cmd_r <= acc_r[CW-1:0];
            end
        end
    end

    assign acc_q   = acc_r;
    assign cy_q    = cy_r;
    assign cmd_sel = cmd_r;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(acc_q) && $stable(cy_q) && $stable(cmd_sel))); // R2

    AST_DEC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_DEC) |=> (cy_q == ($past(acc_q) != '0))); // R5

    AST_RAL_RING: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_RAL)
        |=> (acc_q == {$past(acc_q[DW-2:0]), $past(cy_q)} && cy_q == $past(acc_q[DW-1]))); // R6

    AST_KEY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_KEY)
        |=> ((acc_q <= DW'(KEY_MAX) || acc_q == '1) && $stable(cy_q))); // R8

    AST_BSEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_BSEL)
        |=> (cmd_sel == $past(acc_q[CW-1:0]) && $stable(acc_q) && $stable(cy_q))); // R9

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && op_code == OP_BSEL) |=> $stable(cmd_sel)); // R9

    AST_LDI_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_LDI) |=> (acc_q == $past(idx_val) && $stable(cy_q))); // R10

endmodule

// File: tb/nib_acc_unit_test.sv
// Bench: seeded random operations plus directed corners, compared with a
// reference model written from the requirements.
module nib_acc_unit_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_code = 4'd0;
    logic [3:0] idx_val = 4'd0;
    logic [3:0] acc_q;
    logic       cy_q;
    logic [2:0] cmd_sel;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Expected state carried by the model.
    logic [3:0] m_acc = 4'd0;
    logic       m_cy = 1'b0;
    logic [2:0] m_cmd = 3'd0;

    always #10 clk = ~clk;

    nib_acc_unit uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_code  (op_code),
        .idx_val  (idx_val),
        .acc_q    (acc_q),
        .cy_q     (cy_q),
        .cmd_sel  (cmd_sel)
    );

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd1:          return "R3 add";
            4'd2:          return "R4 sub";
            4'd3, 4'd4:    return "R5 inc/dec";
            4'd5, 4'd6:    return "R6 rotate";
            4'd7, 4'd8, 4'd9, 4'd10, 4'd11: return "R7 clear/set/complement";
            4'd12:         return "R8 key compress";
            4'd13:         return "R9 bank select";
            4'd14:         return "R10 load operand";
            default:       return "R2 no-op";
        endcase
    endfunction

    function automatic logic [3:0] key_ref(input logic [3:0] v);
        case (v)
            4'b0000: return 4'd0;
            4'b0001: return 4'd1;
            4'b0010: return 4'd2;
            4'b0100: return 4'd3;
            4'b1000: return 4'd4;
            default: return 4'd15;
        endcase
    endfunction

    // Advance the model by one operation.
    task automatic model_step(input logic [3:0] op, input logic [3:0] idx);
        int s;
        logic [3:0] a = m_acc;
        logic c = m_cy;
        case (op)
            4'd1: begin s = int'(a) + int'(idx) + int'(c); m_acc = s[3:0]; m_cy = s[4]; end
            4'd2: begin s = int'(a) + (15 - int'(idx)) + int'(c); m_acc = s[3:0]; m_cy = s[4]; end
            4'd3: begin m_acc = a + 4'd1; m_cy = (a == 4'd15); end
            4'd4: begin m_acc = a - 4'd1; m_cy = (a != 4'd0); end
            4'd5: begin m_acc = {a[2:0], c}; m_cy = a[3]; end
            4'd6: begin m_acc = {c, a[3:1]}; m_cy = a[0]; end
            4'd7: begin m_acc = 4'd0; m_cy = 1'b0; end
            4'd8: m_cy = 1'b0;
            4'd9: m_cy = 1'b1;
            4'd10: m_cy = ~c;
            4'd11: m_acc = ~a;
            4'd12: m_acc = key_ref(a);
            4'd13: m_cmd = a[2:0];
            4'd14: m_acc = idx;
            default: ;
        endcase
    endtask

    task automatic check_state(input string tag);
        n_chk++;
        if (acc_q !== m_acc || cy_q !== m_cy || cmd_sel !== m_cmd) begin
            n_fail++;
            $display("FAIL %s: got acc=%0d cy=%0d cmd=%0d expected acc=%0d cy=%0d cmd=%0d",
                     tag, acc_q, cy_q, cmd_sel, m_acc, m_cy, m_cmd);
        end
    endtask

    // One strobed operation followed by a check one edge later.
    task automatic do_op(input logic [3:0] op, input logic [3:0] idx);
        @(negedge clk);
        op_valid = 1'b1;
        op_code  = op;
        idx_val  = idx;
        model_step(op, idx);
        @(negedge clk);
        op_valid = 1'b0;
        check_state(tag_of(op));
    endtask

    task automatic set_state(input logic [3:0] a, input logic c);
        do_op(4'd14, a);
        do_op(c ? 4'd9 : 4'd8, 4'd0);
    endtask

    initial begin
        void'($urandom(32'd4004));
        repeat (3) @(negedge clk);
        check_state("R1 reset");
        rst_n = 1'b1;

        // R3 add with overflow into carry.
        set_state(4'd9, 1'b1);
        do_op(4'd1, 4'd7);
        // R4 subtract, no borrow pending and borrow produced.
        set_state(4'd5, 1'b1);
        do_op(4'd2, 4'd3);
        set_state(4'd2, 1'b0);
        do_op(4'd2, 4'd6);
        // R5 wrap corners.
        set_state(4'd15, 1'b0);
        do_op(4'd3, 4'd0);
        set_state(4'd0, 1'b1);
        do_op(4'd4, 4'd0);
        // R6 rotations through carry.
        set_state(4'b1010, 1'b1);
        do_op(4'd5, 4'd0);
        do_op(4'd6, 4'd0);
        // R8 every single-bit, zero and an error pattern.
        for (int v = 0; v < 16; v++) begin
            set_state(4'(v), 1'b1);
            do_op(4'd12, 4'd0);
        end
        // R2 strobeless cycles and reserved code.
        set_state(4'd11, 1'b1);
        @(negedge clk);
        op_code = 4'd14;
        idx_val = 4'd3;
        repeat (2) @(negedge clk);
        check_state("R2 idle ignores inputs");
        do_op(4'd15, 4'd6);
        do_op(4'd0, 4'd6);

        // R11 back-to-back: load then bank select, add then rotate.
        @(negedge clk);
        op_valid = 1'b1; op_code = 4'd14; idx_val = 4'd6;
        model_step(4'd14, 4'd6);
        @(negedge clk);
        check_state("R11 load before select");
        op_code = 4'd13;
        model_step(4'd13, 4'd6);
        @(negedge clk);
        check_state("R11 select reads new acc (R9)");
        op_code = 4'd1; idx_val = 4'd12;
        model_step(4'd1, 4'd12);
        @(negedge clk);
        check_state("R11 add");
        op_code = 4'd5;
        model_step(4'd5, 4'd12);
        @(negedge clk);
        op_valid = 1'b0;
        check_state("R11 rotate after add");

        // Random mix of all codes.
        for (int k = 0; k < 400; k++) begin
            do_op(4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)));
        end

        // R1 reset mid-run clears everything.
        @(negedge clk);
        rst_n = 1'b0;
        m_acc = 4'd0; m_cy = 1'b0; m_cmd = 3'd0;
        @(negedge clk);
        check_state("R1 reset after activity");
        rst_n = 1'b1;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule